// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block is one configuration slice of a memory controller. It keeps three configuration registers that a config-space read/write port reaches: an SMRAM control byte, an extended SMRAM control byte, and a 16-bit register from which firmware can query the size of an extended TSEG. From the state of these registers it classifies each memory request in the same cycle the request arrives. Each classification uses the request address, a flag that says the CPU is in system-management mode, and a flag that says the requester is a bus master. The request goes to ordinary memory, to the legacy video path, to memory through a high alias of the legacy window, or to a blocked response.

Firmware sets up the SMRAM windows and then sets a one-way lock bit. After that the protected controls stay frozen until reset. The TSEG region sits directly below the top-of-low-memory input, and its size comes from a two-bit code. Three code values pick fixed sizes. The fourth picks a size set at build time, and firmware learns that size by writing all ones to the query register and reading it back.

Top module: `smram_tseg_ctrl`

## Requirements
- R1: After reset, SMRAM control (offset 0x9D) reads 0x00 and extended control (offset 0x9E) reads 0x38. The query register (offset 0x50) reads the build-time extended size EXT_MB, which is 16 by default, or 0 when EXT_MB is 0.
- R2: A read strobe returns its data on cfg_rdata one clock later, and unmapped offsets read 0. In the SMRAM control byte, bit 0 is the global enable, bit 1 is open and bit 2 is lock. In the extended control byte, bit 0 is the TSEG enable, bits 2:1 are the size code and bit 6 is the high-alias enable.
- R3: With EXT_MB nonzero, writing 0xFFFF to offset 0x50 makes a later read return EXT_MB. Any other written value is held and read back as written. EXT_MB is clamped to 4095.
- R4: With EXT_MB equal to 0, offset 0x50 reads 0 and ignores writes, and size code 11 gives no TSEG region, so no access is blocked because of TSEG.
- R5: The TSEG base is tolm minus the size, where size code 00 is 1 MB, 01 is 2 MB, 10 is 8 MB and 11 is EXT_MB megabytes. The region is [base, tolm).
- R6: Writing 1 to the lock bit sets it, and only a reset clears it. While it is set, writes leave SMRAM bits 1:0 and extended-control bits 6, 2:1 and 0 unchanged.
- R7: Extended-control bits 5:3 always read 1, whatever value is written.
- R8: Route codes are 00 memory, 01 legacy video and 10 blocked. An access to 0xA0000-0xBFFFF routes to memory only when global enable is 1, high-alias enable is 0, and either the requester is an SMM CPU cycle that is not a bus master or open is 1. Otherwise it routes to video.
- R9: With global enable and high-alias enable both set, an access to 0xFEDA0000-0xFEDBFFFF routes to memory at address 0xA0000 plus its offset into the window, under the same privilege-or-open rule as R8, and is blocked otherwise. With high-alias enable clear, the window passes through unchanged.
- R10: With global enable and TSEG enable both set, an access inside the TSEG region routes to memory only for an SMM CPU cycle that is not a bus master. It is blocked for every other access.
- R11: A blocked request returns all ones on req_rdata and drops fwd_wr. Any other request passes mem_rdata and req_wr through. All routing outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_rd | input | 1 | Config read strobe |
| cfg_addr | input | CAW | Config byte offset |
| cfg_wdata | input | 16 | Config write data (byte registers use bits 7:0) |
| cfg_rdata | output | 16 | Registered config read data |
| tolm | input | AW | Top of low memory |
| req_addr | input | AW | Request address |
| req_smm | input | 1 | CPU is in system-management mode |
| req_bm | input | 1 | Request comes from a bus master |
| req_wr | input | 1 | Request is a write |
| mem_rdata | input | DW | Read data from the selected target |
| route | output | 2 | Route code (00 memory, 01 video, 10 blocked) |
| route_addr | output | AW | Address forwarded to the target |
| fwd_wr | output | 1 | Write strobe forwarded to the target |
| req_rdata | output | DW | Read data returned to the requester |

## Verification
A table of routing vectors sends addresses on both sides of each window edge and of the TSEG base. Each address goes out as an SMM CPU cycle, as a non-SMM cycle and as a bus-master cycle. This shows whether the privilege rule, and not just the address range, drives the decision. Later directed sequences step the size code through all four values to catch a wrong base. They use the open bit and the high-alias bit to tell window selection apart from address translation. A second instance built with EXT_MB of 0 shows the legacy meaning of code 11 and of the query register. The lock sequence tries to clear lock and change each protected field, then resets to show the freeze does not outlive reset.

// File: rtl/smram_pkg.sv
package smram_pkg;
  typedef enum logic [1:0] {
    RT_MEM   = 2'b00,
    RT_VGA   = 2'b01,
    RT_BLOCK = 2'b10
  } route_e;

  localparam logic [7:0] OFF_EXT  = 8'h50;
  localparam logic [7:0] OFF_SMC  = 8'h9D;
  localparam logic [7:0] OFF_ESMC = 8'h9E;

  localparam int SMC_GEN   = 0;
  localparam int SMC_OPEN  = 1;
  localparam int SMC_LOCK  = 2;
  localparam int ESMC_TEN  = 0;
  localparam int ESMC_SZ   = 1;
  localparam int ESMC_HEN  = 6;

  localparam logic [7:0] SMC_WMASK  = 8'h03;
  localparam logic [7:0] ESMC_WMASK = 8'h47;
  localparam logic [7:0] ESMC_CACHE = 8'h38;

  localparam logic [31:0] LOW_LO = 32'h000A_0000;
  localparam logic [31:0] LOW_HI = 32'h000B_FFFF;
  localparam logic [31:0] HI_LO  = 32'hFEDA_0000;
  localparam logic [31:0] HI_HI  = 32'hFEDB_FFFF;
  localparam int          WIN_BITS = 17;
  localparam int          MAX_EXT_MB = 4095;

  typedef struct packed {
    logic       g_en;
    logic       open;
    logic       t_en;
    logic       h_en;
    logic [1:0] sz;
  } ctl_t;
endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
  import smram_pkg::*;
#(
  parameter int CAW    = 8,
  parameter int EXT_MB = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic           cfg_rd,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [15:0]    cfg_wdata,
  output logic [15:0]    cfg_rdata,
  output logic [7:0]     smc_q,
  output logic [7:0]     esmc_q,
  output logic [15:0]    ext_q,
  output ctl_t           ctl
);
  localparam int EXT_EFF = (EXT_MB > MAX_EXT_MB) ? MAX_EXT_MB : EXT_MB;

  logic [7:0] smc_r, esmc_r, smc_nx, esmc_nx, w8;
  logic       hit_smc, hit_esmc, hit_ext;

  assign w8       = cfg_wdata[7:0];
  assign hit_smc  = (cfg_addr == CAW'(OFF_SMC));
  assign hit_esmc = (cfg_addr == CAW'(OFF_ESMC));
  assign hit_ext  = (cfg_addr == CAW'(OFF_EXT));

  always_comb begin
    smc_nx  = smc_r;
    esmc_nx = esmc_r;
    if (cfg_wr && hit_smc) begin
      if (!smc_r[SMC_LOCK])
        smc_nx = (smc_r & ~SMC_WMASK) | (w8 & SMC_WMASK);
      smc_nx[SMC_LOCK] = smc_r[SMC_LOCK] | w8[SMC_LOCK];
    end
    if (cfg_wr && hit_esmc && !smc_r[SMC_LOCK])
      esmc_nx = (esmc_r & ~ESMC_WMASK) | (w8 & ESMC_WMASK) | ESMC_CACHE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smc_r  <= 8'h00;
      esmc_r <= ESMC_CACHE;
    end else begin
      smc_r  <= smc_nx;
      esmc_r <= esmc_nx;
    end
  end

  generate
    if (EXT_EFF != 0) begin : g_ext
      logic [15:0] ext_r;
      always_ff @(posedge clk) begin
        if (rst)
          ext_r <= 16'(EXT_EFF);
        else if (cfg_wr && hit_ext)
          ext_r <= (cfg_wdata == 16'hFFFF) ? 16'(EXT_EFF) : cfg_wdata;
      end
      assign ext_q = ext_r;
    end else begin : g_noext
      assign ext_q = 16'h0000;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      cfg_rdata <= 16'h0000;
    else if (cfg_rd) begin
      if (hit_smc)       cfg_rdata <= {8'h00, smc_r};
      else if (hit_esmc) cfg_rdata <= {8'h00, esmc_r};
      else if (hit_ext)  cfg_rdata <= ext_q;
      else               cfg_rdata <= 16'h0000;
    end
  end

  assign smc_q    = smc_r;
  assign esmc_q   = esmc_r;
  assign ctl.g_en = smc_r[SMC_GEN];
  assign ctl.open = smc_r[SMC_OPEN];
  assign ctl.t_en = esmc_r[ESMC_TEN];
  assign ctl.h_en = esmc_r[ESMC_HEN];
  assign ctl.sz   = esmc_r[ESMC_SZ +: 2];
endmodule

// File: rtl/smram_tseg_calc.sv
module smram_tseg_calc
  import smram_pkg::*;
#(
  parameter int AW     = 32,
  parameter int EXT_MB = 16
) (
  input  logic [1:0]    sz,
  input  logic [AW-1:0] tolm,
  output logic [AW-1:0] base,
  output logic          has_size
);
  localparam int EXT_EFF = (EXT_MB > MAX_EXT_MB) ? MAX_EXT_MB : EXT_MB;
  localparam int MBW     = 12;

  logic [MBW-1:0] mb;
  logic [AW-1:0]  size_b;

  always_comb begin
    case (sz)
      2'b00:   mb = MBW'(1);
      2'b01:   mb = MBW'(2);
      2'b10:   mb = MBW'(8);
      default: mb = MBW'(EXT_EFF);
    endcase
  end

  assign size_b   = {{(AW-MBW){1'b0}}, mb} << 20;
  assign has_size = (mb != '0);
  assign base     = tolm - size_b;
endmodule

// File: rtl/smram_router.sv
module smram_router
  import smram_pkg::*;
#(
  parameter int AW = 32
) (
  input  ctl_t          ctl,
  input  logic [AW-1:0] tseg_base,
  input  logic          tseg_has,
  input  logic [AW-1:0] tolm,
  input  logic [AW-1:0] req_addr,
  input  logic          req_smm,
  input  logic          req_bm,
  output route_e        route,
  output logic [AW-1:0] route_addr
);
  localparam logic [AW-1:0] A_LOW_LO = AW'(LOW_LO);
  localparam logic [AW-1:0] A_LOW_HI = AW'(LOW_HI);
  localparam logic [AW-1:0] A_HI_LO  = AW'(HI_LO);
  localparam logic [AW-1:0] A_HI_HI  = AW'(HI_HI);
  localparam logic [AW-1:0] WIN_MASK = AW'((1 << WIN_BITS) - 1);

  logic priv, reach, in_low, in_high, in_tseg;

  assign priv    = req_smm & ~req_bm;
  assign reach   = priv | ctl.open;
  assign in_low  = (req_addr >= A_LOW_LO) && (req_addr <= A_LOW_HI);
  assign in_high = (req_addr >= A_HI_LO) && (req_addr <= A_HI_HI);
  assign in_tseg = ctl.g_en && ctl.t_en && tseg_has &&
                   (req_addr >= tseg_base) && (req_addr < tolm);

  always_comb begin
    route      = RT_MEM;
    route_addr = req_addr;
    if (in_low) begin
      if (!(ctl.g_en && !ctl.h_en && reach))
        route = RT_VGA;
    end else if (in_high && ctl.g_en && ctl.h_en) begin
      if (reach)
        route_addr = A_LOW_LO | (req_addr & WIN_MASK);
      else
        route = RT_BLOCK;
    end else if (in_tseg && !priv) begin
      route = RT_BLOCK;
    end
  end
endmodule

// File: rtl/smram_tseg_ctrl.sv
module smram_tseg_ctrl
  import smram_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int CAW    = 8,
  parameter int EXT_MB = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic           cfg_rd,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [15:0]    cfg_wdata,
  output logic [15:0]    cfg_rdata,
  input  logic [AW-1:0]  tolm,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_smm,
  input  logic           req_bm,
  input  logic           req_wr,
  input  logic [DW-1:0]  mem_rdata,
  output logic [1:0]     route,
  output logic [AW-1:0]  route_addr,
  output logic           fwd_wr,
  output logic [DW-1:0]  req_rdata
);
  ctl_t          ctl;
  logic [7:0]    smc_q, esmc_q;
  logic [15:0]   ext_q;
  logic [AW-1:0] tseg_base;
  logic          tseg_has;
  route_e        rt;

  smram_cfg_regs #(.CAW(CAW), .EXT_MB(EXT_MB)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .smc_q(smc_q), .esmc_q(esmc_q), .ext_q(ext_q), .ctl(ctl)
  );

  smram_tseg_calc #(.AW(AW), .EXT_MB(EXT_MB)) u_calc (
    .sz(ctl.sz), .tolm(tolm), .base(tseg_base), .has_size(tseg_has)
  );

  smram_router #(.AW(AW)) u_route (
    .ctl(ctl), .tseg_base(tseg_base), .tseg_has(tseg_has), .tolm(tolm),
    .req_addr(req_addr), .req_smm(req_smm), .req_bm(req_bm),
    .route(rt), .route_addr(route_addr)
  );

  assign route     = rt;
  assign fwd_wr    = req_wr & (rt != RT_BLOCK);
  assign req_rdata = (rt == RT_BLOCK) ? {DW{1'b1}} : mem_rdata;
endmodule

// File: rtl/smram_tseg_ctrl_chk.sv
module smram_tseg_ctrl_chk
  import smram_pkg::*;
#(
  parameter int CAW    = 8,
  parameter int EXT_MB = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           cfg_wr,
  input logic [CAW-1:0] cfg_addr,
  input logic [15:0]    cfg_wdata,
  input logic [7:0]     smc_q,
  input logic [7:0]     esmc_q,
  input logic [15:0]    ext_q,
  input logic [1:0]     route,
  input logic           fwd_wr
);
  localparam int EXT_EFF = (EXT_MB > MAX_EXT_MB) ? MAX_EXT_MB : EXT_MB;

  // R6: the lock never falls once set
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    smc_q[SMC_LOCK] |=> smc_q[SMC_LOCK]);

  // R6: locked SMRAM control fields stay put across a write
  a_r6_smc_frozen: assert property (@(posedge clk) disable iff (rst)
    (smc_q[SMC_LOCK] && cfg_wr && cfg_addr == CAW'(OFF_SMC)) |=> $stable(smc_q[1:0]));

  // R6: locked extended control stays put across a write
  a_r6_esmc_frozen: assert property (@(posedge clk) disable iff (rst)
    (smc_q[SMC_LOCK] && cfg_wr && cfg_addr == CAW'(OFF_ESMC)) |=> $stable(esmc_q));

  // R3 and R4: an all-ones write yields the configured size (zero in legacy build)
  a_r3_query: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == CAW'(OFF_EXT) && cfg_wdata == 16'hFFFF) |=> ext_q == 16'(EXT_EFF));

  // R11: no write reaches a target on a blocked route
  a_r11_no_blocked_write: assert property (@(posedge clk) disable iff (rst)
    fwd_wr |-> route != RT_BLOCK);
endmodule

bind smram_tseg_ctrl smram_tseg_ctrl_chk #(.CAW(CAW), .EXT_MB(EXT_MB)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .smc_q(smc_q), .esmc_q(esmc_q), .ext_q(ext_q),
  .route(route), .fwd_wr(fwd_wr)
);

// File: tb/smram_tseg_ctrl_bench.sv
module smram_tseg_ctrl_bench;
  localparam int AW = 32;
  localparam int DW = 32;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr, cfg_rd;
  logic [7:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [AW-1:0] tolm, req_addr;
  logic        req_smm, req_bm, req_wr;
  logic [DW-1:0] mem_rdata;

  logic [15:0] m_rdata, l_rdata;
  logic [1:0]  m_route, l_route;
  logic [AW-1:0] m_raddr, l_raddr;
  logic        m_fwr, l_fwr;
  logic [DW-1:0] m_rd, l_rd;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] rv_m, rv_l;

  always #2 clk = ~clk;

  smram_tseg_ctrl u_smram_tseg_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(m_rdata), .tolm(tolm), .req_addr(req_addr),
    .req_smm(req_smm), .req_bm(req_bm), .req_wr(req_wr), .mem_rdata(mem_rdata),
    .route(m_route), .route_addr(m_raddr), .fwd_wr(m_fwr), .req_rdata(m_rd)
  );

  smram_tseg_ctrl #(.EXT_MB(0)) u_legacy (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(l_rdata), .tolm(tolm), .req_addr(req_addr),
    .req_smm(req_smm), .req_bm(req_bm), .req_wr(req_wr), .mem_rdata(mem_rdata),
    .route(l_route), .route_addr(l_raddr), .fwd_wr(l_fwr), .req_rdata(l_rd)
  );

  // {addr, smm, bm, route, expected address}; set up: global en, TSEG en, 8 MB, tolm 1 GB
  localparam logic [67:0] VEC [0:11] = '{
    {32'h000A_0000, 1'b0, 1'b0, 2'b01, 32'h000A_0000},
    {32'h000A_0000, 1'b1, 1'b0, 2'b00, 32'h000A_0000},
    {32'h000B_FFFF, 1'b1, 1'b1, 2'b01, 32'h000B_FFFF},
    {32'h0009_FFFF, 1'b0, 1'b0, 2'b00, 32'h0009_FFFF},
    {32'h000C_0000, 1'b0, 1'b0, 2'b00, 32'h000C_0000},
    {32'h3F7F_FFFF, 1'b0, 1'b0, 2'b00, 32'h3F7F_FFFF},
    {32'h3F80_0000, 1'b0, 1'b0, 2'b10, 32'h3F80_0000},
    {32'h3F80_0000, 1'b1, 1'b0, 2'b00, 32'h3F80_0000},
    {32'h3FFF_FFFF, 1'b1, 1'b1, 2'b10, 32'h3FFF_FFFF},
    {32'h4000_0000, 1'b0, 1'b0, 2'b00, 32'h4000_0000},
    {32'hFEDA_0000, 1'b0, 1'b0, 2'b00, 32'hFEDA_0000},
    {32'hFEDB_FFFF, 1'b0, 1'b1, 2'b00, 32'hFEDB_FFFF}
  };

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(logic [7:0] a);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    rv_m = m_rdata; rv_l = l_rdata;
  endtask

  task automatic probe(logic [31:0] a, logic s, logic b);
    @(negedge clk);
    req_addr = a; req_smm = s; req_bm = b;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_wr = 0; cfg_rd = 0; cfg_addr = 0; cfg_wdata = 0;
    tolm = 32'h4000_0000; req_addr = 0; req_smm = 0; req_bm = 0; req_wr = 0;
    mem_rdata = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    cfg_read(8'h9D); chk("R1 smc", rv_m, 16'h0000);
    cfg_read(8'h9E); chk("R1 esmc", rv_m, 16'h0038);
    cfg_read(8'h50); chk("R1 ext main", rv_m, 16'h0010);
    chk("R1 ext legacy", rv_l, 16'h0000);
    cfg_read(8'h60); chk("R2 unmapped", rv_m, 16'h0000);
    probe(32'h000A_0000, 1'b1, 1'b0); chk("R8 closed after reset", m_route, 2'b01);
    probe(32'h3FFF_FFFF, 1'b0, 1'b0); chk("R10 TSEG off after reset", m_route, 2'b00);

    // set up and R7 cache bits
    cfg_write(8'h9D, 16'h0001);
    cfg_write(8'h9E, 16'h0005);
    cfg_read(8'h9E); chk("R7 cache bits read one", rv_m, 16'h003D);
    cfg_read(8'h9D); chk("R2 smc readback", rv_m, 16'h0001);

    // vector table: R8, R9, R10
    for (int i = 0; i < 12; i++) begin
      probe(VEC[i][67:36], VEC[i][35], VEC[i][34]);
      chk($sformatf("R8/R10 vec%0d route", i), m_route, VEC[i][33:32]);
      chk($sformatf("R9 vec%0d addr", i), m_raddr, VEC[i][31:0]);
    end

    // R11 blocked data path
    req_wr = 1'b1;
    probe(32'h3F80_0000, 1'b0, 1'b0);
    chk("R11 blocked wr", m_fwr, 1'b0);
    chk("R11 blocked rdata", m_rd, 32'hFFFF_FFFF);
    probe(32'h3F7F_FFFF, 1'b0, 1'b0);
    chk("R11 pass wr", m_fwr, 1'b1);
    chk("R11 pass rdata", m_rd, 32'h1234_5678);
    req_wr = 1'b0;

    // R5 size codes
    cfg_write(8'h9E, 16'h0001);
    probe(32'h3FEF_FFFF, 1'b0, 1'b0); chk("R5 1MB below", m_route, 2'b00);
    probe(32'h3FF0_0000, 1'b0, 1'b0); chk("R5 1MB base", m_route, 2'b10);
    cfg_write(8'h9E, 16'h0003);
    probe(32'h3FDF_FFFF, 1'b0, 1'b0); chk("R5 2MB below", m_route, 2'b00);
    probe(32'h3FE0_0000, 1'b0, 1'b0); chk("R5 2MB base", m_route, 2'b10);
    cfg_write(8'h9E, 16'h0007);
    probe(32'h3EFF_FFFF, 1'b0, 1'b0); chk("R5 ext below", m_route, 2'b00);
    probe(32'h3F00_0000, 1'b0, 1'b0); chk("R5 ext base", m_route, 2'b10);
    chk("R4 legacy code 11 no TSEG", l_route, 2'b00);
    probe(32'h3FFF_FFFF, 1'b0, 1'b1); chk("R4 legacy top", l_route, 2'b00);

    // R3 query register
    cfg_write(8'h50, 16'h1234);
    cfg_read(8'h50); chk("R3 plain store", rv_m, 16'h1234);
    chk("R4 legacy ignores write", rv_l, 16'h0000);
    cfg_write(8'h50, 16'hFFFF);
    cfg_read(8'h50); chk("R3 query size", rv_m, 16'h0010);
    chk("R4 legacy query", rv_l, 16'h0000);

    // R8 open and global enable
    cfg_write(8'h9E, 16'h0005);
    cfg_write(8'h9D, 16'h0003);
    probe(32'h000A_0000, 1'b0, 1'b1); chk("R8 open reaches mem", m_route, 2'b00);
    cfg_write(8'h9D, 16'h0000);
    probe(32'h000A_0000, 1'b1, 1'b0); chk("R8 global off", m_route, 2'b01);

    // R9 high alias
    cfg_write(8'h9D, 16'h0001);
    cfg_write(8'h9E, 16'h0045);
    probe(32'h000A_0000, 1'b1, 1'b0); chk("R9 low left to video", m_route, 2'b01);
    probe(32'hFEDA_0000, 1'b0, 1'b0); chk("R9 high blocked", m_route, 2'b10);
    probe(32'hFEDB_1234, 1'b1, 1'b0);
    chk("R9 high smm route", m_route, 2'b00);
    chk("R9 high smm addr", m_raddr, 32'h000B_1234);
    cfg_write(8'h9D, 16'h0003);
    probe(32'hFEDA_0010, 1'b0, 1'b1);
    chk("R9 high open route", m_route, 2'b00);
    chk("R9 high open addr", m_raddr, 32'h000A_0010);

    // R6 lock
    cfg_write(8'h9D, 16'h0005);
    cfg_read(8'h9D); chk("R6 lock set", rv_m, 16'h0005);
    cfg_write(8'h9D, 16'h0002);
    cfg_read(8'h9D); chk("R6 smc frozen", rv_m, 16'h0005);
    cfg_write(8'h9E, 16'h0000);
    cfg_read(8'h9E); chk("R6 esmc frozen", rv_m, 16'h007D);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    cfg_read(8'h9D); chk("R6 reset clears lock", rv_m, 16'h0000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule